// File: doc/BRIEF.md
# Counting-Ramp ADC Conversion Controller

This block sequences a staircase (counting) analog-to-digital conversion. A start pulse clears a binary counter whose value is presented directly as the code for an external DAC. On every following clock, while an external comparator shows the DAC level still below the held analog input, the counter advances by one code. On the first clock where the comparator reports the DAC level at or above the input, the counter value is captured as the result, a one-clock done strobe is raised and the block goes idle.

The result is therefore the input divided by the step size, rounded up. The conversion time depends on the input: a result of k takes k+1 busy clocks. The worst case is a full sweep of 2^N−1 steps, and on average half of that. If the comparator never trips, the counter stops at all ones and reports full scale instead of wrapping. The analog DAC, the comparator and the sample-and-hold are outside the block. They appear only as the code output and one comparator input bit.

Top module: `ramp_adc_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous reset), `busy_o`, `done_o`, `dac_code_o` and `result_o` are all zero after that edge.
- R2: A `start_i` pulse sampled while `busy_o` is low sets `busy_o` high and `dac_code_o` to zero after that edge.
- R3: While busy with `cmp_ge_i` low and the code below all ones, `dac_code_o` rises by exactly one per clock.
- R4: On the first busy clock where `cmp_ge_i` is high, `result_o` takes the current `dac_code_o`, `done_o` goes high and `busy_o` goes low after that edge.
- R5: If the code reaches all ones while `cmp_ge_i` is still low, the conversion ends with `result_o` all ones. The code never wraps to zero.
- R6: A `start_i` pulse sampled while `busy_o` is high has no effect; counting continues and the result is unchanged.
- R7: `done_o` is high for exactly one clock per conversion.
- R8: `result_o` keeps its value until the next conversion completes, whatever the other inputs do.
- R9: With a comparator that is high when code×STEP ≥ input, the result equals the input divided by STEP, rounded up. Two inputs within one step of each other inside the same interval give the same code.
- R10: A conversion that ends with result k keeps `busy_o` high for k+1 clocks; the worst case (full scale) is 2^N clocks of busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start-of-conversion request, sampled when idle |
| cmp_ge_i | input | 1 | Comparator: high when DAC level is at or above the analog input |
| dac_code_o | output | WIDTH | Counter value driving the external DAC |
| busy_o | output | 1 | High from accepted start until the result is latched |
| done_o | output | 1 | One-clock end-of-conversion strobe |
| result_o | output | WIDTH | Latched conversion result |

## Verification
The bench builds the block with its default WIDTH of 8 and models the analog side as an integer input level and a step of 40 units. This keeps a full 255-step sweep short enough to run several times. Inputs that land exactly on a step, just above a step, at zero, at exact full scale and beyond full scale therefore exercise rounding, the immediate trip, the last code and saturation. A start issued mid-sweep and input changes after completion check the ignore and hold rules against a reference model that runs every clock.

// File: rtl/ramp_adc_pkg.sv
package ramp_adc_pkg;
  typedef enum logic [0:0] {
    RAMP_IDLE  = 1'b0,
    RAMP_CLIMB = 1'b1
  } ramp_state_e;
endpackage

// File: rtl/ramp_adc_counter.sv
module ramp_adc_counter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             advance,
  output logic [WIDTH-1:0] code,
  output logic             at_top
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  function automatic logic [WIDTH-1:0] next_code(input logic [WIDTH-1:0] c);
    return (c == TOP) ? TOP : c + 1'b1;
  endfunction

  logic [WIDTH-1:0] code_q;

  always_ff @(posedge clk) begin
    if (rst)          code_q <= '0;
    else if (clear)   code_q <= '0;
    else if (advance) code_q <= next_code(code_q);
  end

  assign code   = code_q;
  assign at_top = (code_q == TOP);

  assert_step_one_R3: assert property (@(posedge clk) disable iff (rst)
    (advance && !clear) |=> (code == $past(code) + 1'b1));

  assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (at_top && !clear) |=> at_top);
endmodule

// File: rtl/ramp_adc_seq.sv
module ramp_adc_seq
  import ramp_adc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic cmp_ge,
  input  logic at_top,
  output logic accept,
  output logic advance,
  output logic finish,
  output logic busy,
  output logic done
);
  ramp_state_e state_q;
  logic        done_q;
  logic        climbing;
  logic        reached;

  assign climbing = (state_q == RAMP_CLIMB);
  assign reached  = cmp_ge || at_top;
  assign accept   = start && !climbing;
  assign finish   = climbing && reached;
  assign advance  = climbing && !reached;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RAMP_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= finish;
      case (state_q)
        RAMP_IDLE:  if (accept) state_q <= RAMP_CLIMB;
        RAMP_CLIMB: if (reached) state_q <= RAMP_IDLE;
        default:    state_q <= RAMP_IDLE;
      endcase
    end
  end

  assign busy = climbing;
  assign done = done_q;

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !reached) |=> (busy && !done));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_finish_drops_busy_R4: assert property (@(posedge clk) disable iff (rst)
    finish |=> (done && !busy));
endmodule

// File: rtl/ramp_adc_result.sv
module ramp_adc_result #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] code,
  output logic [WIDTH-1:0] result
);
  logic [WIDTH-1:0] result_q;

  always_ff @(posedge clk) begin
    if (rst)       result_q <= '0;
    else if (load) result_q <= code;
  end

  assign result = result_q;

  assert_capture_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (result == $past(code)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(result));
endmodule

// File: rtl/ramp_adc_ctrl.sv
module ramp_adc_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cmp_ge_i,
  output logic [WIDTH-1:0] dac_code_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam logic [WIDTH-1:0] FULL_SCALE = {WIDTH{1'b1}};

  logic start_accept;
  logic count_step;
  logic conv_finish;
  logic code_at_top;

  ramp_adc_counter #(.WIDTH(WIDTH)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .clear   (start_accept),
    .advance (count_step),
    .code    (dac_code_o),
    .at_top  (code_at_top)
  );

  ramp_adc_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start_i),
    .cmp_ge  (cmp_ge_i),
    .at_top  (code_at_top),
    .accept  (start_accept),
    .advance (count_step),
    .finish  (conv_finish),
    .busy    (busy_o),
    .done    (done_o)
  );

  ramp_adc_result #(.WIDTH(WIDTH)) u_result (
    .clk    (clk),
    .rst    (rst),
    .load   (conv_finish),
    .code   (dac_code_o),
    .result (result_o)
  );

  assert_clear_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> (dac_code_o == '0));

  assert_saturate_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_o && dac_code_o == FULL_SCALE && !cmp_ge_i) |=>
      (result_o == FULL_SCALE && done_o && !busy_o));

  assert_one_finish_R7: assert property (@(posedge clk) disable iff (rst)
    $countones({conv_finish, start_accept}) <= 1);
endmodule

// File: tb/ramp_adc_ctrl_test.sv
module ramp_adc_ctrl_test;
  localparam int W    = 8;
  localparam int STEP = 40;
  localparam int MAXC = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  int           vin = 0;
  logic         cmp_ge;
  logic [W-1:0] dac_code, result;
  logic         busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  // analog side: DAC level versus held input
  assign cmp_ge = (int'(dac_code) * STEP >= vin);

  ramp_adc_ctrl #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .start_i(start), .cmp_ge_i(cmp_ge),
    .dac_code_o(dac_code), .busy_o(busy), .done_o(done), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // behavioural reference, advanced each rising edge
  int m_cnt = 0, m_res = 0;
  bit m_busy = 0, m_done = 0;
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0; m_res = 0; m_busy = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (!m_busy) begin
        if (start) begin m_busy = 1; m_cnt = 0; end
      end else if (m_cnt * STEP >= vin || m_cnt == MAXC) begin
        m_res = m_cnt; m_done = 1; m_busy = 0;
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(dac_code) == m_cnt, "R3 code", int'(dac_code), m_cnt);
      chk(busy == m_busy, "R2 busy", busy, m_busy);
      chk(done == m_done, "R7 done", done, m_done);
      chk(int'(result) == m_res, "R8 result", int'(result), m_res);
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      report();
    end
  end

  function automatic int round_up(input int v);
    int q = v / STEP;
    if (q * STEP < v) q++;
    return (q > MAXC) ? MAXC : q;
  endfunction

  task automatic convert(input int v, input bit mid_start);
    int  busy_n = 0;
    bit  seen = 0;
    int  exp = round_up(v);
    vin = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 400 && !seen; i++) begin
      if (busy) busy_n++;
      if (mid_start && i == 5) start = 1'b1;
      if (mid_start && i == 6) start = 1'b0;
      if (done) seen = 1;
      else @(negedge clk);
    end
    chk(seen, "R4 done seen", seen, 1);
    chk(int'(result) == exp, mid_start ? "R6 result" : "R9 result", int'(result), exp);
    chk(busy_n == exp + 1, "R10 busy clocks", busy_n, exp + 1);
    if (exp == MAXC) chk(int'(result) == MAXC, "R5 full scale", int'(result), MAXC);
    @(negedge clk);
    chk(!done, "R7 single pulse", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done, "R1 flags", {busy, done}, 0);
    chk(dac_code == 0 && result == 0, "R1 data", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    convert(6005, 0);
    convert(6035, 0);
    chk(int'(result) == 151, "R9 same code", int'(result), 151);
    convert(0, 0);
    convert(4000, 0);
    convert(10200, 0);
    convert(20000, 0);
    chk(int'(dac_code) == MAXC, "R5 no wrap", int'(dac_code), MAXC);
    convert(1, 0);
    convert(4000, 1);
    vin = 200;
    repeat (6) @(negedge clk);
    chk(int'(result) == 100, "R8 hold", int'(result), 100);
    rst = 1'b1;
    @(negedge clk);
    chk(result == 0 && dac_code == 0 && !busy && !done, "R1 rerun", int'(result), 0);
    report();
  end
endmodule